// File: doc/BRIEF.md
# Configurable Pipelined Signed Multiplier

This block multiplies two signed two's-complement operands (18 bits each by default) and returns the full-width signed product (36 bits by default). Three optional pipeline registers can be placed in the datapath: one on the first operand, one on the second operand and one on the product. Each register is kept or left out per instance by a parameter. Each register that is kept has its own load enable and its own synchronous clear.

The second operand comes from one of two sources, fixed at elaboration. It is either a direct input port or a chain input fed by a neighbouring multiplier. The value that actually reaches the multiplier's second input is also driven on a chain output, so several instances can share one operand in a row. The clock and each of the six enable and clear inputs have a parameter that flips their active level, which lets the block sit under logic of either polarity without extra inverters.

Top module: `smul_pipe`

## Requirements
- R1: `prod` equals the signed product of the two operand values that currently feed the multiplier, over the full width with no truncation. The most negative operand squared (-131072 × -131072) gives +2^34.
- R2: When `B_SRC` is `BSRC_DIRECT`, the second operand is taken from `op_b` and `casc_b_in` has no effect. When it is `BSRC_CASCADE`, the second operand is taken from `casc_b_in` and `op_b` has no effect.
- R3: `casc_b_out` carries the second operand as the multiplier sees it. It is the B register's content when `USE_BREG` is 1, and it follows the selected source combinationally when `USE_BREG` is 0.
- R4: A configuration with no registers is purely combinational. Otherwise, after both operands change together with all enables active, the new product appears after one clock edge per register stage in its path: one for the input stage (A register, B register or both) and one for the product register.
- R5: A present register loads its input on the rising clock edge when its enable is active and its clear is inactive. It keeps its content while its enable is inactive.
- R6: A present register whose clear is active at a clock edge becomes zero, even if its enable is active at the same edge.
- R7: The product register captures the product of the current multiplier inputs, whether those come from registers or from ports. Its enable and clear act independently of the input stages.
- R8: Setting `INV_CEA`, `INV_RSTA`, `INV_CEB`, `INV_RSTB`, `INV_CEP` or `INV_RSTP` to 1 makes that control active low. `INV_CLK` set to 1 moves capture to the falling clock edge.
- R9: With no product register and only one input register, `prod` responds at once to a change on the unregistered operand, and to clock edges for the registered one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; its capture edge is set by `INV_CLK` |
| a_ce | input | 1 | Load enable of the A register |
| a_rst | input | 1 | Synchronous clear of the A register |
| b_ce | input | 1 | Load enable of the B register |
| b_rst | input | 1 | Synchronous clear of the B register |
| p_ce | input | 1 | Load enable of the product register |
| p_rst | input | 1 | Synchronous clear of the product register |
| op_a | input | A_W | First signed operand |
| op_b | input | B_W | Second signed operand, direct source |
| casc_b_in | input | B_W | Second signed operand, chain source |
| casc_b_out | output | B_W | Second operand as seen by the multiplier |
| prod | output | A_W+B_W | Signed product |

## Verification
The bound checker inspects every capture edge. It checks the clear, load and hold rules of the B and product registers, that the chain output matches the selected source when there is no B register, and that a fully combinational instance always yields the exact product. It also checks that an unregistered-input product register captures the product from the edge before. Three things appear only in the bench's scenarios, which run sixteen instances side by side, one for each register and source combination: per-configuration latency, the mixed old/new operand products while a pipeline fills, and the active-low control variant. The bench also covers arithmetic corners such as the most negative value squared, and the rule that the unselected source is ignored.

// File: rtl/smul_pkg.sv
package smul_pkg;

    typedef enum logic {
        BSRC_DIRECT  = 1'b0,
        BSRC_CASCADE = 1'b1
    } b_src_e;

    typedef struct packed {
        logic ce;
        logic clr;
    } stage_ctl_t;

    localparam int DEF_A_W = 18;
    localparam int DEF_B_W = 18;

endpackage

// File: rtl/smul_ctl_pol.sv
module smul_ctl_pol
    import smul_pkg::*;
#(
    parameter bit INV_CE  = 1'b0,
    parameter bit INV_CLR = 1'b0
) (
    input  logic       ce_raw,
    input  logic       clr_raw,
    output stage_ctl_t ctl
);
    // Normalise both controls to active-high.
    always_comb begin
        ctl.ce  = ce_raw ^ INV_CE;
        ctl.clr = clr_raw ^ INV_CLR;
    end
endmodule

// File: rtl/smul_opt_reg.sv
module smul_opt_reg
    import smul_pkg::*;
#(
    parameter int W       = 18,
    parameter bit PRESENT = 1'b1
) (
    input  logic                clk,
    input  stage_ctl_t          ctl,
    input  logic signed [W-1:0] d,
    output logic signed [W-1:0] q
);
    generate
        if (PRESENT) begin : g_reg
            // Clear dominates load.
            always_ff @(posedge clk) begin
                if (ctl.clr)
                    q <= '0;
                else if (ctl.ce)
                    q <= d;
            end
        end else begin : g_wire
            logic unused_ctl;
            assign unused_ctl = ^{clk, ctl};
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/smul_core.sv
module smul_core #(
    parameter int A_W = 18,
    parameter int B_W = 18,
    localparam int P_W = A_W + B_W
) (
    input  logic signed [A_W-1:0] a,
    input  logic signed [B_W-1:0] b,
    output logic signed [P_W-1:0] p
);
    logic signed [P_W-1:0] a_ext;
    logic signed [P_W-1:0] b_ext;

    // Sign-extend to the full product width before multiplying.
    assign a_ext = P_W'(a);
    assign b_ext = P_W'(b);
    assign p     = a_ext * b_ext;
endmodule

// File: rtl/smul_pipe.sv
module smul_pipe
    import smul_pkg::*;
#(
    parameter int     A_W      = DEF_A_W,
    parameter int     B_W      = DEF_B_W,
    parameter bit     USE_AREG = 1'b1,
    parameter bit     USE_BREG = 1'b1,
    parameter bit     USE_PREG = 1'b1,
    parameter b_src_e B_SRC    = BSRC_DIRECT,
    parameter bit     INV_CLK  = 1'b0,
    parameter bit     INV_CEA  = 1'b0,
    parameter bit     INV_RSTA = 1'b0,
    parameter bit     INV_CEB  = 1'b0,
    parameter bit     INV_RSTB = 1'b0,
    parameter bit     INV_CEP  = 1'b0,
    parameter bit     INV_RSTP = 1'b0,
    localparam int    P_W      = A_W + B_W
) (
    input  logic                  clk,
    input  logic                  a_ce,
    input  logic                  a_rst,
    input  logic                  b_ce,
    input  logic                  b_rst,
    input  logic                  p_ce,
    input  logic                  p_rst,
    input  logic signed [A_W-1:0] op_a,
    input  logic signed [B_W-1:0] op_b,
    input  logic signed [B_W-1:0] casc_b_in,
    output logic signed [B_W-1:0] casc_b_out,
    output logic signed [P_W-1:0] prod
);
    logic                  clk_i;
    stage_ctl_t            ctl_a, ctl_b, ctl_p;
    logic signed [B_W-1:0] b_src;
    logic signed [A_W-1:0] a_q;
    logic signed [B_W-1:0] b_q;
    logic signed [P_W-1:0] mul_w;

    assign clk_i = clk ^ INV_CLK;

    smul_ctl_pol #(.INV_CE(INV_CEA), .INV_CLR(INV_RSTA)) u_pol_a (
        .ce_raw(a_ce), .clr_raw(a_rst), .ctl(ctl_a));
    smul_ctl_pol #(.INV_CE(INV_CEB), .INV_CLR(INV_RSTB)) u_pol_b (
        .ce_raw(b_ce), .clr_raw(b_rst), .ctl(ctl_b));
    smul_ctl_pol #(.INV_CE(INV_CEP), .INV_CLR(INV_RSTP)) u_pol_p (
        .ce_raw(p_ce), .clr_raw(p_rst), .ctl(ctl_p));

    // Second-operand source, fixed at elaboration.
    generate
        if (B_SRC == BSRC_CASCADE) begin : g_src_casc
            logic unused_direct;
            assign unused_direct = ^op_b;
            assign b_src = casc_b_in;
        end else begin : g_src_dir
            logic unused_casc;
            assign unused_casc = ^casc_b_in;
            assign b_src = op_b;
        end
    endgenerate

    smul_opt_reg #(.W(A_W), .PRESENT(USE_AREG)) u_reg_a (
        .clk(clk_i), .ctl(ctl_a), .d(op_a), .q(a_q));
    smul_opt_reg #(.W(B_W), .PRESENT(USE_BREG)) u_reg_b (
        .clk(clk_i), .ctl(ctl_b), .d(b_src), .q(b_q));

    smul_core #(.A_W(A_W), .B_W(B_W)) u_core (
        .a(a_q), .b(b_q), .p(mul_w));

    smul_opt_reg #(.W(P_W), .PRESENT(USE_PREG)) u_reg_p (
        .clk(clk_i), .ctl(ctl_p), .d(mul_w), .q(prod));

    assign casc_b_out = b_q;
endmodule

// File: rtl/smul_pipe_chk.sv
module smul_pipe_chk
    import smul_pkg::*;
#(
    parameter int     A_W      = 18,
    parameter int     B_W      = 18,
    parameter bit     USE_AREG = 1'b1,
    parameter bit     USE_BREG = 1'b1,
    parameter bit     USE_PREG = 1'b1,
    parameter b_src_e B_SRC    = BSRC_DIRECT,
    parameter bit     INV_CLK  = 1'b0,
    parameter bit     INV_CEA  = 1'b0,
    parameter bit     INV_RSTA = 1'b0,
    parameter bit     INV_CEB  = 1'b0,
    parameter bit     INV_RSTB = 1'b0,
    parameter bit     INV_CEP  = 1'b0,
    parameter bit     INV_RSTP = 1'b0,
    localparam int    P_W      = A_W + B_W
) (
    input logic                  clk,
    input logic                  a_ce,
    input logic                  a_rst,
    input logic                  b_ce,
    input logic                  b_rst,
    input logic                  p_ce,
    input logic                  p_rst,
    input logic signed [A_W-1:0] op_a,
    input logic signed [B_W-1:0] op_b,
    input logic signed [B_W-1:0] casc_b_in,
    input logic signed [B_W-1:0] casc_b_out,
    input logic signed [P_W-1:0] prod
);
    logic                  ck;
    logic                  bce, bclr, pce, pclr, unused_a;
    logic signed [B_W-1:0] bsel;
    logic signed [P_W-1:0] port_prod;

    assign ck        = clk ^ INV_CLK;
    assign bce       = b_ce ^ INV_CEB;
    assign bclr      = b_rst ^ INV_RSTB;
    assign pce       = p_ce ^ INV_CEP;
    assign pclr      = p_rst ^ INV_RSTP;
    assign unused_a  = ^{a_ce, a_rst, INV_CEA, INV_RSTA};
    assign bsel      = (B_SRC == BSRC_CASCADE) ? casc_b_in : op_b;
    assign port_prod = P_W'(op_a) * P_W'(bsel);

    generate
        if (USE_BREG) begin : g_b
            AST_BREG_CLEAR: assert property (@(posedge ck)
                bclr |=> casc_b_out == '0);                                // R6
            AST_BREG_LOAD: assert property (@(posedge ck) disable iff (bclr)
                bce |=> casc_b_out == $past(bsel));                        // R5
            AST_BREG_HOLD: assert property (@(posedge ck) disable iff (bclr)
                !bce |=> $stable(casc_b_out));                             // R5
        end else begin : g_nob
            AST_CASC_FOLLOWS: assert property (@(posedge ck) disable iff (bclr)
                casc_b_out == bsel);                                       // R3
        end

        if (USE_PREG) begin : g_p
            AST_PREG_CLEAR: assert property (@(posedge ck)
                pclr |=> prod == '0);                                      // R6
            AST_PREG_HOLD: assert property (@(posedge ck) disable iff (pclr)
                !pce |=> $stable(prod));                                   // R5
            if (!USE_AREG && !USE_BREG) begin : g_pin
                AST_PREG_CAPTURE: assert property (@(posedge ck) disable iff (pclr)
                    pce |=> prod == $past(port_prod));                     // R7
            end
        end else if (!USE_AREG && !USE_BREG) begin : g_comb
            AST_COMB_PRODUCT: assert property (@(posedge ck) disable iff (pclr)
                prod == port_prod);                                        // R1
        end
    endgenerate
endmodule

bind smul_pipe smul_pipe_chk #(
    .A_W(A_W), .B_W(B_W), .USE_AREG(USE_AREG), .USE_BREG(USE_BREG),
    .USE_PREG(USE_PREG), .B_SRC(B_SRC), .INV_CLK(INV_CLK),
    .INV_CEA(INV_CEA), .INV_RSTA(INV_RSTA), .INV_CEB(INV_CEB),
    .INV_RSTB(INV_RSTB), .INV_CEP(INV_CEP), .INV_RSTP(INV_RSTP)
) u_chk (.*);

// File: tb/smul_pipe_tb.sv
module smul_pipe_tb;
    import smul_pkg::*;

    localparam int NCFG = 16;

    logic clk = 1'b0;
    logic a_ce = 1'b1, a_rst = 1'b1, b_ce = 1'b1, b_rst = 1'b1, p_ce = 1'b1, p_rst = 1'b1;
    logic signed [17:0] op_a = '0, op_b = '0, casc_in = '0;
    logic signed [35:0] prod_o [NCFG];
    logic signed [17:0] casc_o [NCFG];
    logic signed [35:0] inv_prod;
    logic signed [17:0] inv_casc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // Config index: bit0 A reg, bit1 B reg, bit2 product reg, bit3 chain source.
    for (genvar gi = 0; gi < NCFG; gi++) begin : g_cfg
        smul_pipe #(
            .USE_AREG(((gi >> 0) & 1) != 0),
            .USE_BREG(((gi >> 1) & 1) != 0),
            .USE_PREG(((gi >> 2) & 1) != 0),
            .B_SRC(((gi >> 3) & 1) != 0 ? BSRC_CASCADE : BSRC_DIRECT)
        ) u_dut (
            .clk(clk), .a_ce(a_ce), .a_rst(a_rst), .b_ce(b_ce), .b_rst(b_rst),
            .p_ce(p_ce), .p_rst(p_rst), .op_a(op_a), .op_b(op_b),
            .casc_b_in(casc_in), .casc_b_out(casc_o[gi]), .prod(prod_o[gi]));
    end

    // All registers, direct source, every control active low (R8).
    smul_pipe #(
        .INV_CEA(1'b1), .INV_RSTA(1'b1), .INV_CEB(1'b1), .INV_RSTB(1'b1),
        .INV_CEP(1'b1), .INV_RSTP(1'b1)
    ) u_inv (
        .clk(clk), .a_ce(~a_ce), .a_rst(~a_rst), .b_ce(~b_ce), .b_rst(~b_rst),
        .p_ce(~p_ce), .p_rst(~p_rst), .op_a(op_a), .op_b(op_b),
        .casc_b_in(casc_in), .casc_b_out(inv_casc), .prod(inv_prod));

    function automatic logic signed [35:0] mul(input logic signed [17:0] x, input logic signed [17:0] y);
        return 36'(x) * 36'(y);
    endfunction

    function automatic logic signed [17:0] bpick(input int c, input logic signed [17:0] b, input logic signed [17:0] k);
        return c[3] ? k : b;
    endfunction

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic look();
        @(negedge clk);
    endtask

    task automatic drive(input logic signed [17:0] a, input logic signed [17:0] b, input logic signed [17:0] k);
        op_a = a; op_b = b; casc_in = k;
    endtask

    task automatic set_all(input logic ce, input logic clr);
        a_ce = ce; b_ce = ce; p_ce = ce;
        a_rst = clr; b_rst = clr; p_rst = clr;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic signed [17:0] a0, b0, k0, a1, b1, k1, a2, b2, k2;
        logic [31:0] seed;
        seed = 32'h1234_5678;

        // Reset state: clear and enable together at the same edge (R6).
        tick();
        drive(18'sd1234, -18'sd77, 18'sd555);
        set_all(1'b1, 1'b1);
        tick();
        look();
        for (int c = 0; c < NCFG; c++) begin
            logic signed [17:0] bs;
            bs = bpick(c, op_b, casc_in);
            check($sformatf("R6 reset prod cfg%0d", c), prod_o[c], (c[2:0] != 0) ? 36'sd0 : mul(op_a, bs));
            check($sformatf("R6/R3 reset casc cfg%0d", c), casc_o[c], c[1] ? 18'sd0 : bs);
        end
        check("R8 inverted reset prod", inv_prod, 36'sd0);

        // Sweep corners and pseudo-random vectors (R1, R2, R3).
        tick();
        set_all(1'b1, 1'b0);
        for (int v = 0; v < 60; v++) begin
            logic signed [17:0] va, vb, vk;
            case (v)
                0: begin va = -18'sd131072; vb = -18'sd131072; vk = 18'sd3; end
                1: begin va = 18'sd131071;  vb = 18'sd131071;  vk = -18'sd131072; end
                2: begin va = -18'sd131072; vb = 18'sd131071;  vk = -18'sd131072; end
                3: begin va = -18'sd1;      vb = -18'sd1;      vk = 18'sd1; end
                4: begin va = 18'sd0;       vb = -18'sd5;      vk = 18'sd131071; end
                5: begin va = 18'sd1;       vb = 18'sd0;       vk = -18'sd1; end
                default: begin
                    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
                    va = seed[17:0];
                    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
                    vb = seed[17:0];
                    vk = seed[31:14];
                end
            endcase
            drive(va, vb, vk);
            tick();
            tick();
            look();
            for (int c = 0; c < NCFG; c++) begin
                logic signed [17:0] bs;
                bs = bpick(c, vb, vk);
                check($sformatf("R1/R2 product cfg%0d vec%0d", c, v), prod_o[c], mul(va, bs));
                check($sformatf("R3 casc out cfg%0d vec%0d", c, v), casc_o[c], bs);
            end
            check($sformatf("R8 inverted controls vec%0d", v), inv_prod, mul(va, vb));
            tick();
        end
        check("R1 min times min", mul(-18'sd131072, -18'sd131072), 36'sd17179869184);

        // Latency and pipeline fill, edge by edge (R4, R9).
        a0 = 18'sd300;  b0 = -18'sd21;  k0 = 18'sd9;
        a1 = -18'sd77;  b1 = 18'sd1001; k1 = -18'sd444;
        drive(a0, b0, k0);
        tick();
        tick();
        drive(a1, b1, k1);
        for (int k = 0; k < 3; k++) begin
            if (k > 0) tick();
            look();
            for (int c = 0; c < NCFG; c++) begin
                logic signed [17:0] ae, be, ap, bp;
                logic signed [35:0] e;
                ae = (c[0] && k == 0) ? a0 : a1;
                be = (c[1] && k == 0) ? bpick(c, b0, k0) : bpick(c, b1, k1);
                ap = (c[0] && k <= 1) ? a0 : a1;
                bp = (c[1] && k <= 1) ? bpick(c, b0, k0) : bpick(c, b1, k1);
                if (c[2])
                    e = (k == 0) ? mul(a0, bpick(c, b0, k0)) : mul(ap, bp);
                else
                    e = mul(ae, be);
                check($sformatf("R4/R9 latency cfg%0d edge%0d", c, k), prod_o[c], e);
                check($sformatf("R3 casc latency cfg%0d edge%0d", c, k), casc_o[c], be);
            end
        end

        // Enables low: registers hold, unregistered paths follow (R5).
        tick();
        a2 = 18'sd5000; b2 = -18'sd3; k2 = 18'sd12;
        set_all(1'b0, 1'b0);
        drive(a2, b2, k2);
        tick();
        tick();
        look();
        for (int c = 0; c < NCFG; c++) begin
            logic signed [17:0] ae, be;
            ae = c[0] ? a1 : a2;
            be = c[1] ? bpick(c, b1, k1) : bpick(c, b2, k2);
            check($sformatf("R5 hold prod cfg%0d", c), prod_o[c], c[2] ? mul(a1, bpick(c, b1, k1)) : mul(ae, be));
            check($sformatf("R5 hold casc cfg%0d", c), casc_o[c], be);
        end
        check("R8 inverted enable hold", inv_prod, mul(a1, b1));

        // Product clear alone leaves the input stages alone (R7).
        tick();
        set_all(1'b1, 1'b0);
        tick();
        tick();
        p_rst = 1'b1;
        tick();
        look();
        for (int c = 0; c < NCFG; c++)
            check($sformatf("R7 product clear cfg%0d", c), prod_o[c], c[2] ? 36'sd0 : mul(a2, bpick(c, b2, k2)));
        tick();
        p_rst = 1'b0;
        tick();
        look();
        for (int c = 0; c < NCFG; c++)
            check($sformatf("R7 product reload cfg%0d", c), prod_o[c], mul(a2, bpick(c, b2, k2)));

        // A clear with enable active, over two edges (R6).
        tick();
        a_rst = 1'b1;
        tick();
        tick();
        look();
        for (int c = 0; c < NCFG; c++)
            check($sformatf("R6 A clear beats enable cfg%0d", c), prod_o[c], c[0] ? 36'sd0 : mul(a2, bpick(c, b2, k2)));
        check("R8 inverted A clear", inv_prod, 36'sd0);
        tick();
        a_rst = 1'b0;

        finish_run();
    end
endmodule